// File: doc/BRIEF.md
# PLL Scan-Chain Reconfiguration Controller

This controller keeps a local copy of a PLL's serial configuration chain. While it is idle, software-side logic can rewrite any bit field of that copy. A reload request then streams the whole copy into the PLL one bit per cycle, most significant bit first, with a scan enable. After the stream it pulses an update strobe and waits for the PLL to report scan completion. A busy flag covers the entire load. If the PLL never answers, a timeout ends the wait and raises an error flag.

The copy is never modified by a load. A new configuration can therefore be formed by rewriting one field and reloading. A reload with no field writes in between streams the full chain again. Data returning from the PLL's scan output is captured only while bits are being shifted, so after a load the capture register holds the configuration the PLL carried before that load. The PLL reset is a registered pass-through of a dedicated input. No other logic drives it.

Top module: `pllcfg_loader`

## Requirements
- R1: After reset, busy, timeout_err, scan_en, scan_dout, scan_update and pll_rst are 0, and capture_q and the local configuration copy are all zero.
- R2: A reload_req that is sampled high at a clock edge while busy is low starts a load. busy reads 1 in the cycle after that edge and is still 0 in the cycle where the request is presented.
- R3: A load holds scan_en high for exactly CHAIN_LEN consecutive cycles. scan_dout carries the copy from bit CHAIN_LEN-1 down to bit 0, one bit per cycle, so a receiver that shifts left on each enabled edge ends up holding the copy exactly.
- R4: scan_update is high for exactly one cycle per load. That cycle immediately follows the last scan_en cycle, and scan_en is low during it.
- R5: After the update strobe, busy stays high until scan_done is sampled high. busy reads 0 in the cycle right after the cycle in which scan_done was high.
- R6: If scan_done does not arrive, busy falls after DONE_TIMEOUT wait cycles, which makes the load CHAIN_LEN+1+DONE_TIMEOUT busy cycles long. timeout_err then reads 1 and stays 1 until the next load starts. A load ended by scan_done leaves timeout_err at 0.
- R7: An accepted field write sets copy bits [cfg_ofs + i] to cfg_val[i] for i from 0 to min(cfg_width, MAX_FIELD)-1. Bits whose index would reach CHAIN_LEN or beyond are dropped. A width of 0 changes nothing, and all other bits are kept.
- R8: A field write is ignored while busy is high, and also when it arrives in the same cycle as reload_req.
- R9: A load leaves the copy unchanged. A second load with no accepted write in between streams the identical full chain again.
- R10: A reload_req that arrives while busy is high is ignored. The running load keeps its length, and no further load follows it.
- R11: capture_q shifts in scan_din, entering at bit 0, only on edges where scan_en is high. After a load it therefore holds the chain contents the PLL had before that load.
- R12: pll_rst equals pll_rst_req delayed by one clock. Loads never assert it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Field write strobe |
| cfg_ofs | input | $clog2(CHAIN_LEN) | Lowest copy bit of the field |
| cfg_width | input | $clog2(MAX_FIELD+1) | Field width in bits (0 = no change, clamped to MAX_FIELD) |
| cfg_val | input | MAX_FIELD | Field value, LSB at cfg_ofs |
| reload_req | input | 1 | Single-cycle request to stream the copy into the PLL |
| pll_rst_req | input | 1 | Reset request forwarded to the PLL (tie low when unused) |
| busy | output | 1 | Load in progress |
| timeout_err | output | 1 | Last load ended without scan_done |
| capture_q | output | CHAIN_LEN | Scan data returned by the PLL during the last load |
| scan_en | output | 1 | Scan clock enable toward the PLL |
| scan_dout | output | 1 | Serial configuration data toward the PLL |
| scan_update | output | 1 | One-cycle strobe that applies the shifted chain |
| pll_rst | output | 1 | Registered PLL reset |
| scan_din | input | 1 | Serial data returned from the PLL chain |
| scan_done | input | 1 | PLL reports that the update is complete |

## Verification
The assertions assume that reload_req is a pulse, that scan_done only comes after an update strobe, and that scan_done is never high while the controller waits in idle. The bench's PLL model raises scan_done once, a bounded number of cycles after the strobe, and it is disabled entirely on the timeout runs. The stimulus pulses reload_req for one cycle, except for the deliberate requests made during busy. The model's completion delay is always drawn below DONE_TIMEOUT, so every completing run ends through scan_done and not through the timer.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_UPDATE,
    ST_WAIT
  } seq_state_e;

endpackage

// File: rtl/pllcfg_cache.sv
// Local copy of the PLL configuration chain with masked field writes.
// Requires CHAIN_LEN >= MAX_FIELD.
module pllcfg_cache #(
  parameter int CHAIN_LEN = 144,
  parameter int MAX_FIELD = 16,
  localparam int OFS_W = $clog2(CHAIN_LEN),
  localparam int FW_W  = $clog2(MAX_FIELD + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [OFS_W-1:0]     wr_ofs,
  input  logic [FW_W-1:0]      wr_width,
  input  logic [MAX_FIELD-1:0] wr_val,
  output logic [CHAIN_LEN-1:0] cache_o
);

  logic [MAX_FIELD:0]   one_sh;
  logic [MAX_FIELD-1:0] ones;
  logic [CHAIN_LEN-1:0] bit_mask;
  logic [CHAIN_LEN-1:0] bit_data;

  always_comb begin
    one_sh = (MAX_FIELD + 1)'(1) << wr_width;
    if (wr_width >= FW_W'(MAX_FIELD)) begin
      ones = '1;
    end else begin
      ones = one_sh[MAX_FIELD-1:0] - MAX_FIELD'(1);
    end
    // shifting in chain width drops bits past the end of the chain
    bit_mask = {{(CHAIN_LEN - MAX_FIELD){1'b0}}, ones} << wr_ofs;
    bit_data = {{(CHAIN_LEN - MAX_FIELD){1'b0}}, wr_val} << wr_ofs;
  end

  for (genvar g = 0; g < CHAIN_LEN; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        cache_o[g] <= 1'b0;
      end else if (wr_en && bit_mask[g]) begin
        cache_o[g] <= bit_data[g];
      end
    end
  end

endmodule

// File: rtl/pllcfg_seq.sv
// Load sequencer: shift, update strobe, wait for completion with timeout.
module pllcfg_seq
  import pllcfg_pkg::*;
#(
  parameter int CHAIN_LEN    = 144,
  parameter int DONE_TIMEOUT = 64,
  localparam int CNT_W = $clog2(CHAIN_LEN + 1),
  localparam int TMR_W = $clog2(DONE_TIMEOUT + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [CHAIN_LEN-1:0] cache_i,
  input  logic                 scan_done_i,
  output logic                 busy_o,
  output logic                 scan_en_o,
  output logic                 scan_dout_o,
  output logic                 scan_update_o,
  output logic                 timeout_o
);

  seq_state_e           state;
  logic [CNT_W-1:0]     sent;
  logic [TMR_W-1:0]     tmr;
  logic [CHAIN_LEN-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      sent          <= '0;
      tmr           <= '0;
      shreg         <= '0;
      busy_o        <= 1'b0;
      scan_en_o     <= 1'b0;
      scan_dout_o   <= 1'b0;
      scan_update_o <= 1'b0;
      timeout_o     <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_i) begin
            state       <= ST_SHIFT;
            busy_o      <= 1'b1;
            timeout_o   <= 1'b0;
            scan_en_o   <= 1'b1;
            scan_dout_o <= cache_i[CHAIN_LEN-1];
            shreg       <= cache_i << 1;
            sent        <= CNT_W'(1);
          end
        end
        ST_SHIFT: begin
          if (sent == CNT_W'(CHAIN_LEN)) begin
            state         <= ST_UPDATE;
            scan_en_o     <= 1'b0;
            scan_dout_o   <= 1'b0;
            scan_update_o <= 1'b1;
          end else begin
            scan_dout_o <= shreg[CHAIN_LEN-1];
            shreg       <= shreg << 1;
            sent        <= sent + CNT_W'(1);
          end
        end
        ST_UPDATE: begin
          state         <= ST_WAIT;
          scan_update_o <= 1'b0;
          tmr           <= '0;
        end
        ST_WAIT: begin
          if (scan_done_i) begin
            state  <= ST_IDLE;
            busy_o <= 1'b0;
          end else if (tmr == TMR_W'(DONE_TIMEOUT - 1)) begin
            state     <= ST_IDLE;
            busy_o    <= 1'b0;
            timeout_o <= 1'b1;
          end else begin
            tmr <= tmr + TMR_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pllcfg_capture.sv
// Captures the PLL's returned scan data while bits are being shifted.
module pllcfg_capture #(
  parameter int CHAIN_LEN = 144
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 shift_en,
  input  logic                 din,
  output logic [CHAIN_LEN-1:0] cap_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_o <= '0;
    end else if (shift_en) begin
      cap_o <= {cap_o[CHAIN_LEN-2:0], din};
    end
  end

endmodule

// File: rtl/pllcfg_loader.sv
module pllcfg_loader #(
  parameter int CHAIN_LEN    = 144,
  parameter int MAX_FIELD    = 16,
  parameter int DONE_TIMEOUT = 64,
  localparam int OFS_W = $clog2(CHAIN_LEN),
  localparam int FW_W  = $clog2(MAX_FIELD + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_wr,
  input  logic [OFS_W-1:0]     cfg_ofs,
  input  logic [FW_W-1:0]      cfg_width,
  input  logic [MAX_FIELD-1:0] cfg_val,
  input  logic                 reload_req,
  input  logic                 pll_rst_req,
  output logic                 busy,
  output logic                 timeout_err,
  output logic [CHAIN_LEN-1:0] capture_q,
  output logic                 scan_en,
  output logic                 scan_dout,
  output logic                 scan_update,
  output logic                 pll_rst,
  input  logic                 scan_din,
  input  logic                 scan_done
);

  logic [CHAIN_LEN-1:0] cache_q;
  logic                 wr_accept;
  logic                 load_start;

  // writes lose to a coincident request and are locked out while busy
  assign wr_accept  = cfg_wr & ~busy & ~reload_req;
  assign load_start = reload_req & ~busy;

  pllcfg_cache #(
    .CHAIN_LEN (CHAIN_LEN),
    .MAX_FIELD (MAX_FIELD)
  ) u_cache (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_accept),
    .wr_ofs   (cfg_ofs),
    .wr_width (cfg_width),
    .wr_val   (cfg_val),
    .cache_o  (cache_q)
  );

  pllcfg_seq #(
    .CHAIN_LEN    (CHAIN_LEN),
    .DONE_TIMEOUT (DONE_TIMEOUT)
  ) u_seq (
    .clk           (clk),
    .rst           (rst),
    .start_i       (load_start),
    .cache_i       (cache_q),
    .scan_done_i   (scan_done),
    .busy_o        (busy),
    .scan_en_o     (scan_en),
    .scan_dout_o   (scan_dout),
    .scan_update_o (scan_update),
    .timeout_o     (timeout_err)
  );

  pllcfg_capture #(
    .CHAIN_LEN (CHAIN_LEN)
  ) u_cap (
    .clk      (clk),
    .rst      (rst),
    .shift_en (scan_en),
    .din      (scan_din),
    .cap_o    (capture_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pll_rst <= 1'b0;
    end else begin
      pll_rst <= pll_rst_req;
    end
  end

endmodule

// File: rtl/pllcfg_loader_chk.sv
module pllcfg_loader_chk #(
  parameter int CHAIN_LEN = 144
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 reload_req,
  input logic                 busy,
  input logic                 scan_en,
  input logic                 scan_update,
  input logic                 scan_done,
  input logic                 timeout_err,
  input logic                 pll_rst_req,
  input logic                 pll_rst,
  input logic [CHAIN_LEN-1:0] cache_q
);

  // R2
  busy_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    (reload_req && !busy) |=> busy);

  // R2
  busy_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(reload_req));

  // R3
  shift_inside_busy_chk: assert property (@(posedge clk) disable iff (rst)
    scan_en |-> busy);

  // R4
  update_after_shift_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(scan_en) |-> scan_update);

  // R4
  update_single_chk: assert property (@(posedge clk) disable iff (rst)
    scan_update |=> (!scan_update && !scan_en));

  // R5
  busy_release_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(scan_done) || timeout_err));

  // R6
  timeout_idle_chk: assert property (@(posedge clk) disable iff (rst)
    timeout_err |-> (!busy || !scan_en));

  // R8
  cache_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(cache_q));

  // R12
  rst_high_pass_chk: assert property (@(posedge clk) disable iff (rst)
    pll_rst_req |=> pll_rst);

  // R12
  rst_low_pass_chk: assert property (@(posedge clk) disable iff (rst)
    !pll_rst_req |=> !pll_rst);

endmodule

bind pllcfg_loader pllcfg_loader_chk #(
  .CHAIN_LEN (CHAIN_LEN)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .reload_req  (reload_req),
  .busy        (busy),
  .scan_en     (scan_en),
  .scan_update (scan_update),
  .scan_done   (scan_done),
  .timeout_err (timeout_err),
  .pll_rst_req (pll_rst_req),
  .pll_rst     (pll_rst),
  .cache_q     (cache_q)
);

// File: tb/pllcfg_loader_test.sv
module pllcfg_loader_test;

  localparam int CLK_PERIOD = 10;
  localparam int N     = 144;
  localparam int MAXF  = 16;
  localparam int TO    = 64;
  localparam int OFS_W = $clog2(N);
  localparam int FW_W  = $clog2(MAXF + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_wr = 1'b0;
  logic [OFS_W-1:0] cfg_ofs = '0;
  logic [FW_W-1:0]  cfg_width = '0;
  logic [MAXF-1:0]  cfg_val = '0;
  logic             reload_req = 1'b0;
  logic             pll_rst_req = 1'b0;
  logic             busy, timeout_err, scan_en, scan_dout, scan_update, pll_rst;
  logic [N-1:0]     capture_q;
  logic             scan_din;
  logic             scan_done;

  int n_cmp = 0;
  int n_bad = 0;

  logic [N-1:0] exp_cache = '0;
  logic [N-1:0] pll_chain;
  logic [N-1:0] pll_seed = '0;
  int           done_delay = 5;
  logic         done_en = 1'b1;
  int           dly;

  always #(CLK_PERIOD/2) clk = ~clk;

  pllcfg_loader #(
    .CHAIN_LEN    (N),
    .MAX_FIELD    (MAXF),
    .DONE_TIMEOUT (TO)
  ) uut (
    .clk         (clk),
    .rst         (rst),
    .cfg_wr      (cfg_wr),
    .cfg_ofs     (cfg_ofs),
    .cfg_width   (cfg_width),
    .cfg_val     (cfg_val),
    .reload_req  (reload_req),
    .pll_rst_req (pll_rst_req),
    .busy        (busy),
    .timeout_err (timeout_err),
    .capture_q   (capture_q),
    .scan_en     (scan_en),
    .scan_dout   (scan_dout),
    .scan_update (scan_update),
    .pll_rst     (pll_rst),
    .scan_din    (scan_din),
    .scan_done   (scan_done)
  );

  // PLL model: left-shifting chain, completion pulse after a delay
  always @(posedge clk) begin
    if (rst) begin
      pll_chain <= pll_seed;
      dly       <= 0;
      scan_done <= 1'b0;
    end else begin
      if (scan_en) pll_chain <= {pll_chain[N-2:0], scan_dout};
      scan_done <= 1'b0;
      if (scan_update) begin
        dly <= done_delay;
      end else if (dly > 0) begin
        dly <= dly - 1;
        if (dly == 1 && done_en) scan_done <= 1'b1;
      end
    end
  end
  assign scan_din = pll_chain[N-1];

  function automatic logic [N-1:0] fld_apply(logic [N-1:0] c, int ofs, int wid,
                                             logic [MAXF-1:0] v);
    int w = (wid > MAXF) ? MAXF : wid;
    for (int i = 0; i < w; i++) begin
      if (ofs + i < N) c[ofs + i] = v[i];
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [N-1:0] act, input logic [N-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic set_field(input int ofs, input int wid, input logic [MAXF-1:0] v);
    cfg_ofs   = OFS_W'(ofs);
    cfg_width = FW_W'(wid);
    cfg_val   = v;
  endtask

  task automatic wr_field(input int ofs, input int wid, input logic [MAXF-1:0] v);
    @(negedge clk);
    cfg_wr = 1'b1;
    set_field(ofs, wid, v);
    @(negedge clk);
    cfg_wr = 1'b0;
    exp_cache = fld_apply(exp_cache, ofs, wid, v);
  endtask

  task automatic do_reload(input bit with_done, input bit poke, input bit wr_with_req);
    logic [N-1:0] prev = pll_chain;
    int  en_cnt = 0, upd = 0, busy_cyc = 0;
    bit  prev_en = 0, prev_done = 0, bad_upd = 0, bad_drop = 0, rst_seen = 0;
    done_en    = with_done;
    done_delay = $urandom_range(1, 20);
    @(negedge clk);
    reload_req = 1'b1;
    if (wr_with_req) begin
      cfg_wr = 1'b1;
      set_field($urandom_range(0, N-1), $urandom_range(1, MAXF), MAXF'($urandom));
    end
    chk(busy == 1'b0, "R2", "busy in request cycle", N'(busy), '0);
    @(negedge clk);
    reload_req = 1'b0;
    cfg_wr     = 1'b0;
    chk(busy == 1'b1, "R2", "busy one cycle after request", N'(busy), N'(1));
    for (int c = 0; c < 2000 && busy; c++) begin
      busy_cyc++;
      if (scan_en) en_cnt++;
      if (scan_update) begin
        upd++;
        if (!prev_en || scan_en) bad_upd = 1;
      end
      if (prev_done) bad_drop = 1;
      if (pll_rst) rst_seen = 1;
      prev_done = scan_done;
      prev_en   = scan_en;
      if (poke && en_cnt == 7) begin
        reload_req = 1'b1;
        cfg_wr     = 1'b1;
        set_field($urandom_range(0, N-1), $urandom_range(1, MAXF), MAXF'($urandom));
      end else begin
        reload_req = 1'b0;
        cfg_wr     = 1'b0;
      end
      @(negedge clk);
    end
    reload_req = 1'b0;
    cfg_wr     = 1'b0;
    chk(en_cnt == N, "R3", "scan_en cycle count", N'(en_cnt), N'(N));
    chk(pll_chain == exp_cache, "R3", "chain received by PLL", pll_chain, exp_cache);
    chk(upd == 1 && !bad_upd, "R4", "update strobe count/placement", N'(upd), N'(1));
    chk(capture_q == prev, "R11", "captured returned data", capture_q, prev);
    chk(timeout_err == !with_done, "R6", "timeout flag", N'(timeout_err), N'(!with_done));
    chk(!rst_seen, "R12", "pll_rst during load", N'(rst_seen), '0);
    if (with_done) begin
      chk(prev_done && !bad_drop, "R5", "busy drop after scan_done", N'(bad_drop), '0);
    end else begin
      chk(busy_cyc == N + 1 + TO, "R6", "busy cycles on timeout", N'(busy_cyc), N'(N + 1 + TO));
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!busy && !scan_en, "R10", "no extra load after request during busy",
          N'({busy, scan_en}), '0);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    pll_seed = {$urandom, $urandom, $urandom, $urandom, $urandom};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk({busy, timeout_err, scan_en, scan_dout, scan_update, pll_rst} == '0, "R1",
        "control outputs after reset",
        N'({busy, timeout_err, scan_en, scan_dout, scan_update, pll_rst}), '0);
    chk(capture_q == '0, "R1", "capture after reset", capture_q, '0);

    // R12 reset pass-through
    pll_rst_req = 1'b1;
    #1 chk(pll_rst == 1'b0, "R12", "pll_rst before edge", N'(pll_rst), '0);
    @(negedge clk);
    chk(pll_rst == 1'b1, "R12", "pll_rst high", N'(pll_rst), N'(1));
    pll_rst_req = 1'b0;
    @(negedge clk);
    chk(pll_rst == 1'b0, "R12", "pll_rst low", N'(pll_rst), '0);

    // R1 copy all zero: first load streams zeros, captures seed (R11)
    do_reload(1, 0, 0);

    // R7 directed field writes
    wr_field(N - 4, MAXF, '1);        // clipped at chain end
    wr_field(10, 0, 16'hBEEF);        // width 0: no change
    wr_field(20, 31, 16'hA5C3);       // width clamped to MAX_FIELD
    wr_field(0, 3, 16'hFFFD);         // low bits only
    do_reload(1, 0, 0);
    // R9 repeated load with no writes
    do_reload(1, 0, 0);
    // R10 / R8 request and write while busy
    do_reload(1, 1, 0);
    do_reload(1, 0, 0);
    // R8 write together with request
    do_reload(1, 0, 1);
    do_reload(1, 0, 0);
    // R6 timeout, then recovery
    do_reload(0, 0, 0);
    do_reload(1, 0, 0);

    // random mix
    for (int it = 0; it < 8; it++) begin
      int nw = $urandom_range(0, 3);
      for (int w = 0; w < nw; w++) begin
        wr_field($urandom_range(0, N-1), $urandom_range(0, 31), MAXF'($urandom));
      end
      do_reload($urandom_range(0, 5) != 0, $urandom_range(0, 1), $urandom_range(0, 1));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule